// File: doc/BRIEF.md
# Microcontroller Internal Data Address Decoder

This block turns the operand of one internal-data access into a concrete target inside a small microcontroller's data space. That space has two parts: a 256-byte scratchpad RAM and a special-function register (SFR) space of up to 128 registers. The two overlap on the range 80h–FFh. A direct byte access in that range reaches the SFRs. An indirect access in that range reaches the upper half of the RAM. Working registers R0–R7 sit in four banks at the bottom of RAM, and two bank-select bits from the status word choose the bank. Bit accesses reach either a 16-byte bit field in RAM or the SFRs whose address is a multiple of eight.

On each cycle the instruction sequencer presents one access. The access carries a qualifier, a 2-bit mode, the 8-bit operand, the current bank-select bits and the contents of the two pointer registers of the active bank. One clock later the block presents a registered result:
- a RAM enable with an 8-bit RAM address, or an SFR enable with an 8-bit SFR address;
- a bit strobe with a 3-bit bit index;
- a flag telling whether the selected byte supports bit operations.

The mode is encoded as 00 direct byte, 01 indirect byte, 10 working register and 11 bit.

Top module: `idec_top`

## Requirements
- R1: A direct access (mode 00) with operand 00h–7Fh raises ram_en with ram_addr equal to the operand and sfr_en low.
- R2: A direct access (mode 00) with operand 80h–FFh raises sfr_en with sfr_addr equal to the operand, and ram_en stays low.
- R3: An indirect access (mode 01) raises ram_en with ram_addr equal to wreg1 when operand bit 0 is 1, or wreg0 when it is 0. The pointer may take any value 00h–FFh, and operand bits 7:1 have no effect.
- R4: A working-register access (mode 10) raises ram_en with ram_addr = {3'b000, bank_sel[1:0], operand[2:0]}, and operand bits 7:3 have no effect.
- R5: A bit access (mode 11) with operand below 80h raises ram_en and bit_en with ram_addr = 20h + operand[6:3] and bit_idx = operand[2:0].
- R6: A bit access (mode 11) with operand 80h or above raises sfr_en and bit_en with sfr_addr = {operand[7:3], 3'b000} and bit_idx = operand[2:0].
- R7: bit_ok is high exactly when the selected target is a RAM byte in 20h–2Fh or an SFR address whose low three bits are zero.
- R8: Every output is registered, so results appear one clock after the access is presented. When acc_valid is low, and during reset, all outputs are zero. The address output of the target that is not selected is zero, and bit_idx is zero outside bit mode.
- R9: ram_en and sfr_en are never high together, and bit_en is high only for a bit-mode access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 working register, 11 bit |
| operand | input | 8 | Operand address or register/bit field |
| bank_sel | input | 2 | Working-register bank select from the status word |
| wreg0 | input | 8 | Contents of R0 of the active bank |
| wreg1 | input | 8 | Contents of R1 of the active bank |
| ram_en | output | 1 | Target is scratchpad RAM |
| ram_addr | output | 8 | RAM byte address |
| sfr_en | output | 1 | Target is the SFR space |
| sfr_addr | output | 8 | SFR address (80h–FFh) |
| bit_en | output | 1 | Access is a single-bit access |
| bit_idx | output | 3 | Bit position within the target byte |
| bit_ok | output | 1 | Selected byte supports bit operations |

## Verification
Some properties are checked on every cycle by the assertions:
- the RAM and SFR enables are mutually exclusive;
- a direct access in the upper half always lands in the SFR space;
- a register access keeps the bank bits and stays below 20h;
- an indirect access follows the chosen pointer;
- a bit strobe only ever lands on a bit-capable byte;
- an idle cycle clears all strobes.

Other behaviour can only be shown by the bench's sweeps, which compare every output field against an arithmetic model. Those sweeps cover the exact addresses over all 256 direct and bit operands, all four banks with all eight registers, and every pointer value through both R0 and R1. They also show that the ignored operand bits truly have no effect, that unselected address fields read zero, and that the bit-capable flag has the exact boundaries 1Fh/20h and 2Fh/30h.

// File: rtl/idec_pkg.sv
// Package: shared widths, access-mode encoding and the decoded-target record
// used by every module of the internal data address decoder.
package idec_pkg;

    localparam int ADDR_W     = 8;               // operand / RAM address width
    localparam int BANK_W     = 2;               // bank-select width
    localparam int REG_W      = 3;               // working-register index width
    localparam int BIT_W      = 3;               // bit index width
    localparam int BYTE_SEL_W = ADDR_W - 1 - BIT_W; // bytes in the RAM bit field
    localparam logic [ADDR_W-1:0] BIT_BASE = 8'h20; // first bit-capable RAM byte
    localparam int BIT_BYTES  = 1 << BYTE_SEL_W;    // 16 bit-capable RAM bytes

    // Access modes presented by the sequencer.
    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_INDIRECT = 2'b01,
        MODE_REGISTER = 2'b10,
        MODE_BIT      = 2'b11
    } idec_mode_e;

    // One decoded target.
    typedef struct packed {
        logic              ram_en;
        logic [ADDR_W-1:0] ram_addr;
        logic              sfr_en;
        logic [ADDR_W-1:0] sfr_addr;
        logic              bit_en;
        logic [BIT_W-1:0]  bit_idx;
        logic              bit_ok;
    } idec_tgt_t;

    localparam idec_tgt_t TGT_NONE = '0;

    // True when a RAM byte lies inside the bit-capable field.
    function automatic logic ram_bit_capable(input logic [ADDR_W-1:0] a);
        return (a >= BIT_BASE) && (a < BIT_BASE + ADDR_W'(BIT_BYTES));
    endfunction

    // True when an SFR address is a multiple of eight.
    function automatic logic sfr_bit_capable(input logic [ADDR_W-1:0] a);
        return a[BIT_W-1:0] == '0;
    endfunction

endpackage

// File: rtl/idec_reg_map.sv
// Working-register mapper: places register Rn of the selected bank at
// RAM address {bank, n}. Assumes banks are contiguous from address 0 and
// that BANK_W + REG_W does not exceed ADDR_W.
module idec_reg_map
    import idec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W,
    parameter int RW = REG_W
) (
    input  logic [BW-1:0] bank,
    input  logic [RW-1:0] reg_idx,
    output logic [AW-1:0] addr
);
    localparam int PAD_W = AW - BW - RW;

    // Concatenate the bank and register index, zero above.
    always_comb begin
        addr = {{PAD_W{1'b0}}, bank, reg_idx};
    end
endmodule

// File: rtl/idec_ptr_sel.sv
// Indirect pointer selector: picks R0 or R1 of the active bank as the RAM
// pointer using the low bit of the register field. Assumes the caller
// supplies the register contents already read for the active bank.
module idec_ptr_sel
    import idec_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          pick_r1,
    input  logic [AW-1:0] r0_val,
    input  logic [AW-1:0] r1_val,
    output logic [AW-1:0] ptr
);
    // Two-way pointer multiplexer.
    always_comb begin
        ptr = pick_r1 ? r1_val : r0_val;
    end
endmodule

// File: rtl/idec_bit_map.sv
// Bit-address mapper: turns an 8-bit bit address into a byte target and
// bit index. The lower half addresses the RAM bit field, the upper half
// the SFRs whose address is a multiple of eight.
module idec_bit_map
    import idec_pkg::*;
(
    input  logic [ADDR_W-1:0] bit_addr,
    output idec_tgt_t         tgt
);
    localparam int TOP = ADDR_W - 1;

    // Split the bit address into a byte target and a bit index.
    always_comb begin
        tgt         = TGT_NONE;
        tgt.bit_en  = 1'b1;
        tgt.bit_idx = bit_addr[BIT_W-1:0];
        tgt.bit_ok  = 1'b1;
        if (bit_addr[TOP]) begin
            tgt.sfr_en   = 1'b1;
            tgt.sfr_addr = {bit_addr[TOP:BIT_W], {BIT_W{1'b0}}};
        end else begin
            tgt.ram_en   = 1'b1;
            tgt.ram_addr = BIT_BASE
                         + ADDR_W'(bit_addr[TOP-1:BIT_W]);
        end
    end
endmodule

// File: rtl/idec_top.sv
// Internal data address decoder, top level. Routes one access per cycle to
// scratchpad RAM or the SFR space and registers the result, so outputs
// follow inputs by one clock. Assumes the sequencer supplies R0/R1 of the
// active bank and holds acc_valid low on idle cycles.
module idec_top
    import idec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [1:0]          acc_mode,
    input  logic [ADDR_W-1:0]   operand,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic [ADDR_W-1:0]   wreg0,
    input  logic [ADDR_W-1:0]   wreg1,
    output logic                ram_en,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                sfr_en,
    output logic [ADDR_W-1:0]   sfr_addr,
    output logic                bit_en,
    output logic [BIT_W-1:0]    bit_idx,
    output logic                bit_ok
);
    localparam int TOP = ADDR_W - 1;

    idec_mode_e        mode;
    logic [ADDR_W-1:0] reg_addr;
    logic [ADDR_W-1:0] ptr_addr;
    idec_tgt_t         bit_tgt;
    idec_tgt_t         nxt;
    idec_tgt_t         cur;

    assign mode = idec_mode_e'(acc_mode);

    idec_reg_map u_reg_map (
        .bank    (bank_sel),
        .reg_idx (operand[REG_W-1:0]),
        .addr    (reg_addr)
    );

    idec_ptr_sel u_ptr_sel (
        .pick_r1 (operand[0]),
        .r0_val  (wreg0),
        .r1_val  (wreg1),
        .ptr     (ptr_addr)
    );

    idec_bit_map u_bit_map (
        .bit_addr (operand),
        .tgt      (bit_tgt)
    );

    // Choose the decoded target for the presented access mode.
    always_comb begin
        nxt = TGT_NONE;
        if (acc_valid) begin
            case (mode)
                MODE_DIRECT: begin
                    if (operand[TOP]) begin
                        nxt.sfr_en   = 1'b1;
                        nxt.sfr_addr = operand;
                        nxt.bit_ok   = sfr_bit_capable(operand);
                    end else begin
                        nxt.ram_en   = 1'b1;
                        nxt.ram_addr = operand;
                        nxt.bit_ok   = ram_bit_capable(operand);
                    end
                end
                MODE_INDIRECT: begin
                    nxt.ram_en   = 1'b1;
                    nxt.ram_addr = ptr_addr;
                    nxt.bit_ok   = ram_bit_capable(ptr_addr);
                end
                MODE_REGISTER: begin
                    nxt.ram_en   = 1'b1;
                    nxt.ram_addr = reg_addr;
                    nxt.bit_ok   = ram_bit_capable(reg_addr);
                end
                MODE_BIT: begin
                    nxt = bit_tgt;
                end
                default: nxt = TGT_NONE;
            endcase
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= TGT_NONE;
        else        cur <= nxt;
    end

    assign ram_en   = cur.ram_en;
    assign ram_addr = cur.ram_addr;
    assign sfr_en   = cur.sfr_en;
    assign sfr_addr = cur.sfr_addr;
    assign bit_en   = cur.bit_en;
    assign bit_idx  = cur.bit_idx;
    assign bit_ok   = cur.bit_ok;

    // R9: RAM and SFR targets are exclusive.
    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_en, sfr_en}));

    // R2: upper-half direct access always lands in the SFR space.
    a_r2_direct_upper_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b00 && operand[TOP])
        |=> (sfr_en && !ram_en && sfr_addr == $past(operand)));

    // R1: lower-half direct access lands in RAM at the operand.
    a_r1_direct_lower_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b00 && !operand[TOP])
        |=> (ram_en && !sfr_en && ram_addr == $past(operand)));

    // R3: indirect access follows the selected pointer register.
    a_r3_indirect_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b01)
        |=> (ram_en && ram_addr == ($past(operand[0]) ? $past(wreg1) : $past(wreg0))));

    // R4: register access keeps the bank bits and stays below the bit field.
    a_r4_reg_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b10)
        |=> (ram_en && ram_addr < BIT_BASE && ram_addr[4:3] == $past(bank_sel)));

    // R7: a bit strobe only reaches a bit-capable byte.
    a_r7_bit_target_capable: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> (bit_ok && ((sfr_en && sfr_addr[2:0] == 3'b000)
                   || (ram_en && ram_addr[7:4] == 4'h2))));

    // R8: an idle cycle clears every strobe.
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!ram_en && !sfr_en && !bit_en && bit_idx == '0));

endmodule

// File: tb/idec_top_tb.sv
// Sweep bench for idec_top: every mode over its full operand range, with
// expected targets computed arithmetically.
module idec_top_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [1:0] acc_mode;
    logic [7:0] operand;
    logic [1:0] bank_sel;
    logic [7:0] wreg0;
    logic [7:0] wreg1;
    logic       ram_en;
    logic [7:0] ram_addr;
    logic       sfr_en;
    logic [7:0] sfr_addr;
    logic       bit_en;
    logic [2:0] bit_idx;
    logic       bit_ok;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    idec_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .operand(operand), .bank_sel(bank_sel), .wreg0(wreg0), .wreg1(wreg1),
        .ram_en(ram_en), .ram_addr(ram_addr), .sfr_en(sfr_en), .sfr_addr(sfr_addr),
        .bit_en(bit_en), .bit_idx(bit_idx), .bit_ok(bit_ok)
    );

    // Compare all outputs against an expected vector.
    task automatic compare(input string tag, input logic [22:0] exp);
        logic [22:0] act;
        act = {ram_en, ram_addr, sfr_en, sfr_addr, bit_en, bit_idx, bit_ok};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s mode=%0d op=%02h bank=%0d act=%06h exp=%06h",
                     tag, acc_mode, operand, bank_sel, act, exp);
        end
    endtask

    // Present one access at a falling edge and check one clock later.
    task automatic access(input string tag, input logic v, input logic [1:0] m,
                          input logic [7:0] op, input logic [1:0] bk,
                          input logic [7:0] p0, input logic [7:0] p1);
        logic        e_ram, e_sfr, e_bit, e_ok;
        logic [7:0]  e_ra, e_sa, ptr;
        logic [2:0]  e_bi;
        @(negedge clk);
        acc_valid = v; acc_mode = m; operand = op; bank_sel = bk;
        wreg0 = p0; wreg1 = p1;
        e_ram = 0; e_sfr = 0; e_bit = 0; e_ok = 0; e_ra = 0; e_sa = 0; e_bi = 0;
        if (v) begin
            case (m)
                2'd0: if (op >= 8'h80) begin
                          e_sfr = 1; e_sa = op; e_ok = (op % 8 == 0);
                      end else begin
                          e_ram = 1; e_ra = op; e_ok = (op >= 8'h20 && op <= 8'h2F);
                      end
                2'd1: begin
                          ptr = (op % 2 == 1) ? p1 : p0;
                          e_ram = 1; e_ra = ptr; e_ok = (ptr >= 8'h20 && ptr <= 8'h2F);
                      end
                2'd2: begin
                          e_ram = 1; e_ra = 8'(bk * 8 + op % 8); e_ok = 0;
                      end
                default: begin
                          e_bit = 1; e_bi = 3'(op % 8); e_ok = 1;
                          if (op >= 8'h80) begin e_sfr = 1; e_sa = 8'(op / 8 * 8); end
                          else begin e_ram = 1; e_ra = 8'(8'h20 + op / 8); end
                      end
            endcase
        end
        @(negedge clk);
        compare(tag, {e_ram, e_ra, e_sfr, e_sa, e_bit, e_bi, e_ok});
    endtask

    initial begin
        rst_n = 1'b0; acc_valid = 1'b1; acc_mode = 2'd3; operand = 8'hFF;
        bank_sel = 2'd3; wreg0 = 8'hAA; wreg1 = 8'h55;
        repeat (3) @(negedge clk);
        // R8: reset holds every output at zero even with an access presented.
        compare("R8 reset", 23'h0);
        rst_n = 1'b1;

        // R1 R2 R7 R9: direct access over every operand.
        for (int a = 0; a < 256; a++)
            access("R1 R2 R7 R9 direct", 1'b1, 2'd0, 8'(a), 2'(a), 8'(a ^ 8'h3C), 8'(~a));

        // R3 R7: every pointer value through R0 and through R1, with junk upper operand bits.
        for (int p = 0; p < 256; p++) begin
            access("R3 R7 indirect R0", 1'b1, 2'd1, 8'({p[6:0], 1'b0}), 2'(p), 8'(p), 8'(~p));
            access("R3 R7 indirect R1", 1'b1, 2'd1, 8'({p[6:0], 1'b1}), 2'(p), 8'(~p), 8'(p));
        end

        // R4: all banks, all registers, with upper operand bits varied.
        for (int b = 0; b < 4; b++)
            for (int hi = 0; hi < 32; hi += 5)
                for (int n = 0; n < 8; n++)
                    access("R4 register", 1'b1, 2'd2, 8'(hi * 8 + n), 2'(b), 8'h11, 8'h22);

        // R5 R6 R7 R9: bit access over every bit address.
        for (int a = 0; a < 256; a++)
            access("R5 R6 R7 R9 bit", 1'b1, 2'd3, 8'(a), 2'(a >> 3), 8'h00, 8'hFF);

        // R8: idle cycles in every mode clear the outputs.
        for (int m = 0; m < 4; m++)
            access("R8 idle", 1'b0, 2'(m), 8'hA8, 2'd1, 8'h25, 8'hC0);

        // R8: an access immediately after idle decodes normally.
        access("R8 after idle", 1'b1, 2'd3, 8'h7F, 2'd0, 8'h00, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule